// File: doc/BRIEF.md
# Edge Capture Timer

This block runs a free-running up-counter and timestamps transitions on one external capture pin. A falling transition stores the running count in one capture register, and a rising transition stores it in another. Software can subtract successive values of one register to get the signal period, or subtract a falling stamp from a rising stamp to get the pulse width. Each capture can request an interrupt. The interrupt enables are set separately for each edge direction.

The pin is asynchronous. It passes through a synchroniser chain of flip-flops, and edges are found by comparing the newest synchronised sample with the one before it. A store therefore takes place three clocks after the pin changes, and the interrupt appears in that same cycle. The synchroniser resets to the high level, so the pin is expected to idle high while reset is held. The pin must stay at each level for at least four clocks, so the shortest period is eight clocks.

Software uses a small word-addressed register port. Writes are strobed, and the read data is combinational from the address. A read strobe to a capture register consumes that register's fresh-data flag. Status bits that software clears are cleared by writing a 1 to them.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, every register reads 0: control at address 0, falling stamp at 1, rising stamp at 2, status at 3 and count at 4. The `irq` output is low.
- R2: The counter advances by one on every clock while control bit 0 (run) is 1. It holds its value while run is 0.
- R3: When the count steps from 0xFFFF to 0, status bit 6 (wrap) is set. The bit stays set until a status write with bit 6 at 1 clears it.
- R4: When the pin falls, the falling stamp register takes the count value that was readable in the cycle of the change plus 2 (modulo 2^16). The new value is readable three clocks after the change.
- R5: When the pin rises, the rising stamp register takes the count value that was readable in the cycle of the change plus 2 (modulo 2^16). The new value is readable three clocks after the change.
- R6: A capture sets that register's fresh flag: status bit 0 for falling, bit 1 for rising. A read strobe to address 1 clears bit 0, and a read strobe to address 2 clears bit 1.
- R7: A capture that arrives while that register's fresh flag is still set sets an overrun flag: status bit 2 for falling, bit 3 for rising. A status write with that bit at 1 clears it.
- R8: Each capture sets a pending bit: status bit 4 for falling, bit 5 for rising. `irq` is high while a pending bit is set and its enable is on. Control bit 1 enables falling captures and bit 2 enables rising captures. `irq` rises three clocks after the pin changes.
- R9: A capture whose enable is off still sets its pending bit but leaves `irq` low. Turning the enable on later raises `irq`.
- R10: A status write clears only the bits written as 1, and writing 0 changes nothing. A capture that lands in the same cycle as a clear of its pending bit leaves the pending bit set.
- R11: A capture that lands in the same cycle as a read strobe to its register leaves the fresh flag set and does not set overrun.
- R12: Every edge of a pin waveform whose high and low times are each at least four clocks is captured with the value given in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | 1 | Asynchronous capture pin |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (consumes fresh flags) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A store from the pin can fall in the same clock as a software access that acts on the same state. The access is either a read strobe to that stamp register or a status write that clears its pending bit. The bench provokes this by raising the strobe two clocks after it changes the pin, so the strobe is sampled on the edge where the store happens. It then judges that the capture wins: the fresh flag and the pending bit stay set, no overrun appears, and the stamp holds the new value.

// File: rtl/ect_pkg.sv
// Shared register addresses and status bit positions for the edge capture timer.
// Assumes a data word of at least seven bits.
package ect_pkg;
    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_FALL  = 3'd1,
        A_RISE  = 3'd2,
        A_STAT  = 3'd3,
        A_COUNT = 3'd4
    } reg_addr_e;

    localparam int SLOT_FALL = 0;
    localparam int SLOT_RISE = 1;
    localparam int NUM_SLOTS = 2;

    // Status layout: fresh flags, overrun flags, pending flags, wrap flag
    localparam int ST_NEW  = 0;
    localparam int ST_OVR  = 2;
    localparam int ST_PEND = 4;
    localparam int ST_WRAP = 6;

    // Control layout: run bit, then one interrupt enable per slot
    localparam int CT_RUN = 0;
    localparam int CT_IE  = 1;
endpackage

// File: rtl/ect_edge_sync.sv
// Synchronises the asynchronous capture pin through a flop chain and emits
// one-cycle falling and rising pulses. Assumes STAGES >= 2; the chain resets
// to IDLE so that an idle pin produces no edge after reset.
module ect_edge_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the pin through the chain and keep the previous synchronised sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE}};
            last_q  <= IDLE;
        end else begin
            chain_q[0] <= pin;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    // Compare the newest synchronised sample with the previous one
    always_comb begin
        fall_o = last_q & ~chain_q[STAGES-1];
        rise_o = ~last_q & chain_q[STAGES-1];
    end
endmodule

// File: rtl/ect_counter.sv
// Free-running up-counter that advances while run is high and flags the
// cycle in which it steps from all ones back to zero.
module ect_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] count_q;

    // Advance the count on every enabled clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (run) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Wrap happens on the edge that leaves the all-ones value while running
    always_comb begin
        wrap_o  = run && (count_q == {CNT_W{1'b1}});
        count_o = count_q;
    end
endmodule

// File: rtl/ect_capture_slot.sv
// One capture register with its fresh, overrun and pending flags. A capture
// (hit) always wins over a same-cycle software read or clear.
module ect_capture_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rd_hit,
    input  logic             clr_ovr,
    input  logic             clr_pend,
    output logic [CNT_W-1:0] cap_o,
    output logic             new_o,
    output logic             ovr_o,
    output logic             pend_o
);
    logic [CNT_W-1:0] cap_q;
    logic             new_q;
    logic             ovr_q;
    logic             pend_q;

    // Latch the count on a hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (hit) begin
            cap_q <= cnt;
        end
    end

    // Fresh flag: set by a hit, consumed by a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= 1'b0;
        end else if (hit) begin
            new_q <= 1'b1;
        end else if (rd_hit) begin
            new_q <= 1'b0;
        end
    end

    // Overrun flag: a hit over unread data that is not being read now
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (hit && new_q && !rd_hit) begin
            ovr_q <= 1'b1;
        end else if (clr_ovr) begin
            ovr_q <= 1'b0;
        end
    end

    // Pending flag: set by a hit, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (clr_pend) begin
            pend_q <= 1'b0;
        end
    end

    // Expose the slot state
    always_comb begin
        cap_o  = cap_q;
        new_o  = new_q;
        ovr_o  = ovr_q;
        pend_o = pend_q;
    end
endmodule

// File: rtl/edge_capture_timer.sv
// Edge capture timer top: counter, pin synchroniser, one capture slot per
// edge direction, and the register port. Assumes CNT_W >= 7 so the status
// word fits in a data word; read data is combinational from the address.
module edge_capture_timer
    import ect_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);
    localparam int DATA_W = CNT_W;
    localparam int STAT_W = ST_WRAP + 1;

    logic                             run_q;
    logic [NUM_SLOTS-1:0]             ie_q;
    logic                             wrap_q;
    logic [CNT_W-1:0]                 count_q;
    logic                             wrap_pulse;
    logic [NUM_SLOTS-1:0]             edge_hit;
    logic [NUM_SLOTS-1:0]             rd_slot;
    logic [NUM_SLOTS-1:0]             clr_ovr;
    logic [NUM_SLOTS-1:0]             clr_pend;
    logic [NUM_SLOTS-1:0][CNT_W-1:0]  cap_val;
    logic [NUM_SLOTS-1:0]             new_q;
    logic [NUM_SLOTS-1:0]             ovr_q;
    logic [NUM_SLOTS-1:0]             pend_q;
    logic                             wr_ctrl;
    logic                             wr_stat;
    logic [STAT_W-1:0]                status;
    logic                             wdata_unused;

    ect_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .count_o (count_q),
        .wrap_o  (wrap_pulse)
    );

    ect_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (cap_in),
        .fall_o (edge_hit[SLOT_FALL]),
        .rise_o (edge_hit[SLOT_RISE])
    );

    // Decode register writes
    always_comb begin
        wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
        wr_stat      = reg_wr && (reg_addr == A_STAT);
        wdata_unused = ^reg_wdata[DATA_W-1:STAT_W];
    end

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            localparam logic [2:0] SLOT_ADDR = (s == SLOT_FALL) ? A_FALL : A_RISE;

            // Per-slot read and write-one-to-clear decode
            always_comb begin
                rd_slot[s]  = reg_rd && (reg_addr == SLOT_ADDR);
                clr_ovr[s]  = wr_stat && reg_wdata[ST_OVR + s];
                clr_pend[s] = wr_stat && reg_wdata[ST_PEND + s];
            end

            ect_capture_slot #(.CNT_W(CNT_W)) slot_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .hit      (edge_hit[s]),
                .cnt      (count_q),
                .rd_hit   (rd_slot[s]),
                .clr_ovr  (clr_ovr[s]),
                .clr_pend (clr_pend[s]),
                .cap_o    (cap_val[s]),
                .new_o    (new_q[s]),
                .ovr_o    (ovr_q[s]),
                .pend_o   (pend_q[s])
            );
        end
    endgenerate

    // Control register: run bit and per-edge interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= '0;
        end else if (wr_ctrl) begin
            run_q <= reg_wdata[CT_RUN];
            ie_q  <= reg_wdata[CT_IE +: NUM_SLOTS];
        end
    end

    // Sticky wrap flag, set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
        end else if (wrap_pulse) begin
            wrap_q <= 1'b1;
        end else if (wr_stat && reg_wdata[ST_WRAP]) begin
            wrap_q <= 1'b0;
        end
    end

    // Assemble the status word and the interrupt request
    always_comb begin
        status = {wrap_q, pend_q, ovr_q, new_q};
        irq    = |(pend_q & ie_q);
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = DATA_W'({ie_q, run_q});
            A_FALL:  reg_rdata = cap_val[SLOT_FALL];
            A_RISE:  reg_rdata = cap_val[SLOT_RISE];
            A_STAT:  reg_rdata = DATA_W'(status);
            A_COUNT: reg_rdata = count_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ect_checker.sv
// Assertion checker for the edge capture timer, bound to the top module.
// Capture checks wait until the synchroniser holds only post-reset samples.
module ect_checker
    import ect_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_in,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             wrap_flag,
    input logic [CNT_W-1:0] fall_cap,
    input logic [CNT_W-1:0] rise_cap,
    input logic [1:0]       new_flags,
    input logic [1:0]       ovr_flags,
    input logic             reg_rd,
    input logic [2:0]       reg_addr
);
    logic [2:0] age_q;

    // Count cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != {CNT_W{1'b1}}) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == {CNT_W{1'b1}}) |=> wrap_flag);

    // R4
    fall_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && $past(cap_in, 3) && !$past(cap_in, 2)) |=> fall_cap == $past(cnt));

    // R5
    rise_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && !$past(cap_in, 3) && $past(cap_in, 2)) |=> rise_cap == $past(cnt));

    // R6
    fresh_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(new_flags[SLOT_FALL]) |-> $past(reg_rd && reg_addr == A_FALL));

    // R7
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flags[SLOT_RISE]) |-> $past(new_flags[SLOT_RISE]));
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_in    (cap_in),
    .run       (run_q),
    .cnt       (count_q),
    .wrap_flag (wrap_q),
    .fall_cap  (cap_val[0]),
    .rise_cap  (cap_val[1]),
    .new_flags (new_q),
    .ovr_flags (ovr_q),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr)
);

// File: tb/edge_capture_timer_tb_top.sv
module edge_capture_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_in = 1'b1;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] CTRL = 3'd0, FALL = 3'd1, RISE = 3'd2, STAT = 3'd3, COUNT = 3'd4;

    edge_capture_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stamp_of(logic [15:0] c);
        return c + 16'd2;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic reg_write(logic [2:0] a, logic [15:0] v);
        reg_addr = a;
        reg_wdata = v;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cap_edge(logic level, output logic [15:0] exp);
        logic [15:0] c;
        peek(COUNT, c);
        cap_in = level;
        exp = stamp_of(c);
    endtask

    initial begin
        #(150000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, e, c1, c2, prev_rise;
        int m;
        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        peek(CTRL, d);  chk("R1 ctrl", d, 0);
        peek(FALL, d);  chk("R1 fall", d, 0);
        peek(RISE, d);  chk("R1 rise", d, 0);
        peek(STAT, d);  chk("R1 stat", d, 0);
        peek(COUNT, d); chk("R1 count", d, 0);
        chk("R1 irq", irq, 0);
        tick(3);
        peek(COUNT, d); chk("R2 hold while stopped", d, 0);

        // R2 counting
        reg_write(CTRL, 16'h0007);
        peek(COUNT, c1);
        tick(10);
        peek(COUNT, c2);
        chk("R2 step", c2 - c1, 10);

        // R4, R8 falling capture and interrupt latency
        cap_edge(1'b0, e);
        tick(2);
        chk("R8 irq not early", irq, 0);
        tick(1);
        chk("R8 irq at three clocks", irq, 1);
        peek(FALL, d); chk("R4 fall stamp", d, e);
        peek(STAT, d); chk("R6 fresh+pend fall", d, 16'h0011);
        tick(2);

        // R5 rising capture
        cap_edge(1'b1, e);
        tick(3);
        peek(RISE, d); chk("R5 rise stamp", d, e);
        peek(STAT, d); chk("R6 fresh+pend both", d, 16'h0033);

        // R6 read strobe consumes fresh flag
        reg_read(FALL, d);
        peek(STAT, d); chk("R6 fall fresh cleared", d, 16'h0032);

        // R7 overrun
        tick(2);
        cap_edge(1'b0, e); tick(4);
        cap_edge(1'b1, e); tick(4);
        peek(STAT, d); chk("R7 rise overrun", d, 16'h003B);
        cap_edge(1'b0, e); tick(4);
        peek(STAT, d); chk("R7 fall overrun", d, 16'h003F);

        // R10 write-one-to-clear
        reg_write(STAT, 16'h0000);
        peek(STAT, d); chk("R10 zero write no effect", d, 16'h003F);
        reg_write(STAT, 16'h003C);
        peek(STAT, d); chk("R10 clear ovr+pend", d, 16'h0003);
        chk("R10 irq low after clear", irq, 0);

        // R9 disabled enable
        reg_read(RISE, d);
        reg_read(FALL, d);
        reg_write(CTRL, 16'h0001);
        cap_edge(1'b1, e); tick(4);
        peek(STAT, d); chk("R9 pend set while disabled", d, 16'h0022);
        chk("R9 irq masked", irq, 0);
        reg_write(CTRL, 16'h0005);
        chk("R9 irq after enable", irq, 1);
        reg_write(CTRL, 16'h0003);
        chk("R8 other enable only", irq, 0);
        reg_write(CTRL, 16'h0007);
        reg_write(STAT, 16'h0030);

        // R11 capture in same cycle as read of its register
        cap_edge(1'b0, e); tick(4);
        peek(STAT, d); chk("R11 setup", d, 16'h0013);
        cap_edge(1'b1, e);
        tick(2);
        reg_read(RISE, prev_rise);
        peek(RISE, d); chk("R11 new stamp kept", d, e);
        peek(STAT, d); chk("R11 fresh stays, no overrun", d, 16'h0033);

        // R10 capture in same cycle as pending clear
        tick(1);
        cap_edge(1'b0, e);
        tick(2);
        reg_write(STAT, 16'h0010);
        peek(STAT, d); chk("R10 capture beats clear", d, 16'h0037);
        reg_read(FALL, d);
        reg_read(RISE, d);
        reg_write(STAT, 16'h003C);
        peek(STAT, d); chk("R10 cleaned", d, 16'h0000);

        // R12 random pulse train with minimum widths
        for (int i = 0; i < 40; i++) begin
            int w;
            logic lvl;
            w = 4 + int'($urandom_range(8));
            lvl = ~cap_in;
            cap_edge(lvl, e);
            tick(3);
            peek(lvl ? RISE : FALL, d);
            chk(lvl ? "R12 random rise (R5)" : "R12 random fall (R4)", d, e);
            tick(w - 3);
        end

        // R3 wrap
        peek(COUNT, c1);
        m = 65536 - int'(c1);
        tick(m - 1);
        peek(COUNT, d); chk("R3 count at max", d, 16'hFFFF);
        peek(STAT, d);  chk("R3 wrap not yet", d[6], 0);
        tick(1);
        peek(COUNT, d); chk("R3 count wrapped", d, 0);
        peek(STAT, d);  chk("R3 wrap set", d[6], 1);
        reg_write(STAT, 16'h0040);
        peek(STAT, d);  chk("R3 wrap cleared", d[6], 0);

        // R2 stop
        reg_write(CTRL, 16'h0000);
        peek(COUNT, c1);
        tick(5);
        peek(COUNT, c2);
        chk("R2 stopped holds", c2, c1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule